// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is one stage of a synchronous binary up counter, four bits wide by default. It can be cleared, preset from a data bus, stepped by one, or left unchanged. The clear is asynchronous and active-low. The preset is synchronous and active-low. Counting needs two active-high enables, and they play different roles. The count comes from a register. A combinational terminal-count flag reports when the stage is full and its carry-chain enable is high.

Wider counters are built by chaining stages:
- All stages share one clock.
- All stages share one clear, one load and one count-permit enable.
- Each stage's terminal-count flag drives the carry-chain enable of the next stage up.

The flag is combinational, so the carry crosses the whole chain within one clock period. Every stage therefore changes on the same edge, and a rollover such as all-ones to zero happens in a single cycle.

Top module: `presettable_counter`

## Requirements
- R1: While `clear_n` is low, `count` is 0 at once, with no clock edge needed.
- R2: A low `clear_n` overrides load and count: with `load_n` low and both enables high across a rising edge, `count` stays 0.
- R3: With `clear_n` high and `load_n` low, `data_in` is copied into `count` on the next rising edge, whatever the levels of `cep` and `cet`.
- R4: With `clear_n` and `load_n` high and both `cep` and `cet` high, `count` rises by one on each rising edge.
- R5: With `clear_n` and `load_n` high and either `cep` or `cet` low, `count` keeps its value across the edge.
- R6: `tc` is high exactly when `cet` is high and `count` is all ones (15 at the default width). `cep` has no effect on `tc`, and `tc` follows `cet` in the same cycle.
- R7: Stepping up from all ones gives 0 (modulo 2^WIDTH).
- R8: After `clear_n` goes high between edges, `count` stays 0 until the next rising edge. On that edge the stage loads or counts normally.
- R9: Three stages chained through `tc` into `cet` act as one 12-bit counter. Going from 0xFFF to 0x000 takes one edge, and the top stage's `tc` is high at 0xFFF when the lowest `cet` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel preset, active low |
| cep | input | 1 | Count-permit enable, shared by all stages of a chain |
| cet | input | 1 | Carry-chain enable; also gates `tc` |
| data_in | input | WIDTH | Preset value |
| count | output | WIDTH | Registered count |
| tc | output | 1 | Terminal count: `cet` AND all count bits high |

## Verification
Results arrive with three kinds of timing:
- `tc` is combinational. The bench checks it one nanosecond after new enables are applied, in the same cycle.
- Loads, counts and holds show up on `count` one rising edge after the inputs are applied. The bench drives inputs on the falling edge and compares `count` with its 12-bit reference model at the following falling edge.
- Clear needs no edge. The bench checks `count` a fraction of a nanosecond after `clear_n` falls, between edges. After release, it checks that `count` is still zero before the next rising edge.

// File: rtl/pcnt_pkg.sv
// Package: shared types for the presettable counter stage.
// Assumes: nothing; holds only the mode encoding.
package pcnt_pkg;
    typedef enum logic [1:0] {
        PC_HOLD  = 2'd0,
        PC_COUNT = 2'd1,
        PC_LOAD  = 2'd2
    } pc_mode_e;
endpackage

// File: rtl/pcnt_mode_sel.sv
// Module: pcnt_mode_sel
// Picks the synchronous mode for the next edge. Load wins over count,
// and count wins over hold. Clear is not handled here because it acts
// asynchronously at the register.
// Assumes: inputs are synchronous to the stage clock.
module pcnt_mode_sel
    import pcnt_pkg::*;
(
    input  logic     load_n,
    input  logic     cep,
    input  logic     cet,
    output pc_mode_e mode
);
    // Priority decode of the synchronous controls.
    always_comb begin
        if (!load_n)
            mode = PC_LOAD;
        else if (cep && cet)
            mode = PC_COUNT;
        else
            mode = PC_HOLD;
    end
endmodule

// File: rtl/pcnt_next.sv
// Module: pcnt_next
// Computes the value the register takes on the next edge for the mode
// that was chosen. Incrementing wraps modulo 2^WIDTH.
// Assumes: mode is one of the three legal encodings.
module pcnt_next
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  pc_mode_e         mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Next-value multiplexer.
    always_comb begin
        unique case (mode)
            PC_LOAD:  nxt = preset;
            PC_COUNT: nxt = cur + ONE;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/pcnt_reg.sv
// Module: pcnt_reg
// The count register. An active-low clear zeroes it asynchronously;
// otherwise it samples the next value on each rising edge.
// Assumes: clear_n is released away from the rising clock edge.
module pcnt_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // State register with asynchronous clear.
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            q <= '0;
        else
            q <= d;
    end

    // R1: with clear held low, the register reads zero at every edge.
    assert_clear_zero_R1: assert property (@(posedge clk)
        !clear_n |-> (q == '0));
endmodule

// File: rtl/pcnt_tc.sv
// Module: pcnt_tc
// Terminal-count detect: high when the stage is full and its carry-chain
// enable is high. Purely combinational, so a chain ripples within a cycle.
// Assumes: cet comes from the stage below, or from the chain's own enable.
module pcnt_tc #(
    parameter int WIDTH = 4
) (
    input  logic             cet,
    input  logic [WIDTH-1:0] cur,
    output logic             tc
);
    // AND-reduce the count, then gate with the carry-chain enable.
    always_comb tc = cet & (&cur);
endmodule

// File: rtl/presettable_counter.sv
// Module: presettable_counter
// One cascadable stage of a synchronous binary up counter with an
// asynchronous clear, a synchronous preset and two count enables.
// Assumes: when chained, all stages share clk, clear_n, load_n and cep,
// and each stage's cet is driven by the tc of the stage below.
module presettable_counter
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             cep,
    input  logic             cet,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] count,
    output logic             tc
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    pc_mode_e         mode;
    logic [WIDTH-1:0] nxt;

    pcnt_mode_sel u_mode (
        .load_n (load_n),
        .cep    (cep),
        .cet    (cet),
        .mode   (mode)
    );

    pcnt_next #(.WIDTH(WIDTH)) u_next (
        .mode   (mode),
        .cur    (count),
        .preset (data_in),
        .nxt    (nxt)
    );

    pcnt_reg #(.WIDTH(WIDTH)) u_reg (
        .clk     (clk),
        .clear_n (clear_n),
        .d       (nxt),
        .q       (count)
    );

    pcnt_tc #(.WIDTH(WIDTH)) u_tc (
        .cet (cet),
        .cur (count),
        .tc  (tc)
    );

    // R3: a preset lands on the next edge regardless of the enables.
    assert_load_lands_R3: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> (count == $past(data_in)));

    // R4: both enables high with no preset steps the count by one.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cep && cet) |=> (count == $past(count) + ONE));

    // R5: either enable low with no preset holds the count.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(cep && cet)) |=> $stable(count));

    // R6: tc is never high while the carry-chain enable is low.
    assert_tc_gated_R6: assert property (@(posedge clk) disable iff (!clear_n)
        !cet |-> !tc);

    // R7: counting past terminal count wraps to zero.
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!clear_n)
        (tc && cep && load_n) |=> (count == '0));
endmodule

// File: tb/tb_presettable_counter.sv
`timescale 1ns/1ps
module tb_presettable_counter;
    logic        clk = 1'b0;
    logic        clear_n = 1'b1;
    logic        load_n = 1'b1;
    logic        cep = 1'b0;
    logic        cet = 1'b0;
    logic [11:0] din = '0;
    logic [3:0]  q0, q1, q2;
    logic        tc0, tc1, tc2;
    logic [11:0] ref_cnt = '0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    presettable_counter #(.WIDTH(4)) dut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cep(cep), .cet(cet),
        .data_in(din[3:0]), .count(q0), .tc(tc0));
    presettable_counter #(.WIDTH(4)) dut1 (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cep(cep), .cet(tc0),
        .data_in(din[7:4]), .count(q1), .tc(tc1));
    presettable_counter #(.WIDTH(4)) dut2 (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cep(cep), .cet(tc1),
        .data_in(din[11:8]), .count(q2), .tc(tc2));

    function automatic logic [11:0] model_next(input logic [11:0] cur, input logic ld,
                                               input logic p, input logic t,
                                               input logic [11:0] d);
        if (!ld)        return d;
        else if (p && t) return cur + 12'd1;
        else            return cur;
    endfunction

    task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply inputs just after a falling edge, check tc, then check count one edge later.
    task automatic cycle(input logic ld, input logic p, input logic t,
                         input logic [11:0] d, input string tag);
        logic e0, e1, e2;
        load_n = ld; cep = p; cet = t; din = d;
        #1;
        e0 = t && (ref_cnt[3:0] == 4'hF);
        e1 = e0 && (ref_cnt[7:4] == 4'hF);
        e2 = e1 && (ref_cnt[11:8] == 4'hF);
        chk({11'd0, tc0}, {11'd0, e0}, "R6 tc stage0");
        chk({11'd0, tc2}, {11'd0, e2}, "R9 tc stage2");
        ref_cnt = model_next(ref_cnt, ld, p, t, d);
        @(negedge clk);
        chk({q2, q1, q0}, ref_cnt, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        #1 clear_n = 1'b0;
        #0.5 chk({q2, q1, q0}, 12'h000, "R1 clear without edge");
        // R2: load and both enables active across an edge while clear is low.
        @(negedge clk);
        load_n = 1'b0; cep = 1'b1; cet = 1'b1; din = 12'h5A3;
        @(negedge clk);
        chk({q2, q1, q0}, 12'h000, "R2 clear overrides load");
        #1 clear_n = 1'b1;
        #0.5 chk({q2, q1, q0}, 12'h000, "R8 zero until next edge");
        ref_cnt = 12'h5A3;
        @(negedge clk);
        chk({q2, q1, q0}, ref_cnt, "R8 first edge after release loads");

        cycle(1, 1, 1, 12'h000, "R4 count");
        cycle(1, 1, 1, 12'h000, "R4 count");
        cycle(0, 0, 0, 12'h3C7, "R3 load with enables low");
        cycle(1, 0, 1, 12'h000, "R5 hold cep low");
        cycle(1, 1, 0, 12'h000, "R5 hold cet low");
        cycle(0, 0, 0, 12'h00F, "R3 load");
        cycle(1, 0, 1, 12'h000, "R6 tc with cep low");
        cycle(1, 1, 0, 12'h000, "R6 tc with cet low");
        cycle(1, 1, 1, 12'h000, "R7 nibble wrap");
        cycle(0, 1, 1, 12'hFFD, "R3 load mid-count");
        cycle(1, 1, 1, 12'h000, "R4 count");
        cycle(1, 1, 1, 12'h000, "R4 count");
        cycle(1, 1, 1, 12'h000, "R9 rollover to zero");
        cycle(1, 1, 1, 12'h000, "R4 count after rollover");

        // Clear asserted between edges in the middle of a count.
        cycle(0, 0, 0, 12'h7E9, "R3 load");
        load_n = 1'b1; cep = 1'b1; cet = 1'b1;
        #1 clear_n = 1'b0;
        #0.5 chk({q2, q1, q0}, 12'h000, "R1 mid-cycle clear");
        ref_cnt = '0;
        @(negedge clk);
        chk({q2, q1, q0}, 12'h000, "R2 clear overrides count");
        #1 clear_n = 1'b1;
        #0.5 chk({q2, q1, q0}, 12'h000, "R8 zero after release");
        ref_cnt = 12'h001;
        @(negedge clk);
        chk({q2, q1, q0}, ref_cnt, "R8 counts on first edge");

        // Constrained random mix of preset, count and hold.
        for (int i = 0; i < 600; i++) begin
            logic        ld;
            logic        p, t;
            logic [11:0] d;
            ld = ($urandom % 10) != 0;
            p  = ($urandom % 5) != 0;
            t  = ($urandom % 5) != 0;
            d  = ($urandom % 8 == 0) ? 12'hFFE : 12'($urandom);
            cycle(ld, p, t, d, "R3/R4/R5 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule